// File: doc/BRIEF.md
# Quadrature Digital Downconverter Front End

This block sits right behind a unipolar 10-bit ADC that samples a biased radio signal at the ADC clock rate. It takes off the mid-scale bias so each code becomes a signed sample. It then multiplies that sample by a cosine and a sine from a numerically tuned local oscillator. Each product stream is reduced by 200 in a five-stage cascaded integrator-comb decimator. The result is a pair of signed 16-bit baseband words, in phase (I) and quadrature (Q), marked by a one-cycle strobe.

The oscillator is a 24-bit phase accumulator. Its step is the tuning word, so the mixing frequency is word × f_clk / 2^24. A new word is used on the next clock, and the accumulated phase carries on without a jump. The sine and cosine come from a computed table, and no external memory is needed. The downstream compensation filter and packing logic read the output pair only when the strobe is high.

Top module: `ddc_frontend`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `i_out`/`q_out` are 0 until the first decimated result appears. Reset is asynchronous and active low. Inside the block its release is synchronised over two clock edges.
- R2: The offset-corrected sample is `adc_code − 512`, a signed 10-bit value. A constant code of 512 therefore gives all-zero outputs for any tuning.
- R3: The phase is a 24-bit register. It starts at 0 after reset and adds `tune_word` on every clock, wrapping modulo 2^24. A changed word applies from the next clock, and the phase is not cleared.
- R4: The table has 1024 signed 12-bit entries and is addressed by phase bits [23:14]. Entry k has h = k mod 512 and u = h·(512−h), and its magnitude is floor(2047·4·u / (327680 − u)). The entry is negative for k ≥ 512. Sine uses address a and cosine uses address (a + 256) mod 1024.
- R5: I is the corrected sample times the cosine, and Q is the corrected sample times the sine. Both are full-precision 22-bit signed products, registered once. The sample and the oscillator value in each product are taken at the same clock edge.
- R6: `out_valid` is high for exactly one clock in every 200. The first pulse comes 200 clocks after the internal reset release.
- R7: Each channel runs five cascaded integrators and five combs at a 62-bit width (22 + 5·8) with wrap-around two's-complement arithmetic. The integrators update every clock. The combs update only on the decimation clock.
- R8: Each output word is bits [61:46] of the last comb result. It is loaded on the decimation clock and held unchanged between strobes.
- R9: I and Q become valid on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_code | input | 10 | Unsigned ADC code, biased at mid-scale |
| tune_word | input | 24 | Phase increment per clock |
| i_out | output | 16 | In-phase decimated sample, signed |
| q_out | output | 16 | Quadrature decimated sample, signed |
| out_valid | output | 1 | One-cycle strobe for `i_out`/`q_out` |

## Verification
A bad integrator or comb register does not show up until the next strobe, up to 200 clocks later. Because the integrators never forget, it then corrupts every later output pair rather than a single one. A phase or table error shows up as a wrong ratio between I and Q. It also breaks the values that follow, at the first strobe after the affected samples pass through the five-deep integrator chain. A skewed decimation counter moves the strobe away from its 200-cycle spacing, and that is visible at once on `out_valid`.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int ADC_W  = 10;
  localparam int PH_W   = 24;
  localparam int LUT_AW = 10;
  localparam int LUT_DW = 12;
  localparam int CIC_N  = 5;
  localparam int CIC_R  = 200;
  localparam int OUT_W  = 16;

  // Rational sine approximation over one half period of 'half' steps.
  function automatic longint approx_sine(input int k, input int half, input longint amp);
    longint h;
    longint u;
    longint mag;
    h   = longint'(k % half);
    u   = h * (longint'(half) - h);
    mag = (4 * amp * u) / ((5 * longint'(half) * longint'(half)) / 4 - u);
    return (k >= half) ? -mag : mag;
  endfunction
endpackage

// File: rtl/ddc_sincos_rom.sv
module ddc_sincos_rom #(
  parameter int AW = ddc_pkg::LUT_AW,
  parameter int DW = ddc_pkg::LUT_DW
) (
  input  logic [AW-1:0]        sin_addr,
  input  logic [AW-1:0]        cos_addr,
  output logic signed [DW-1:0] sin_val,
  output logic signed [DW-1:0] cos_val
);
  localparam int     ENTRIES = 2 ** AW;
  localparam int     HALF    = ENTRIES / 2;
  localparam longint AMP     = (longint'(1) <<< (DW - 1)) - 1;

  logic signed [DW-1:0] tbl [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_tbl
    assign tbl[k] = DW'(ddc_pkg::approx_sine(k, HALF, AMP));
  end

  assign sin_val = tbl[sin_addr];
  assign cos_val = tbl[cos_addr];
endmodule

// File: rtl/ddc_nco.sv
module ddc_nco #(
  parameter int PH_W = ddc_pkg::PH_W,
  parameter int AW   = ddc_pkg::LUT_AW,
  parameter int DW   = ddc_pkg::LUT_DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PH_W-1:0]      tune,
  output logic signed [DW-1:0] lo_cos,
  output logic signed [DW-1:0] lo_sin
);
  localparam logic [AW-1:0] QUARTER = AW'(2 ** (AW - 2));

  logic [PH_W-1:0]      phase_q, phase_d;
  logic [AW-1:0]        addr;
  logic signed [DW-1:0] rom_sin, rom_cos;

  assign addr = phase_q[PH_W-1 -: AW];

  ddc_sincos_rom #(.AW(AW), .DW(DW)) u_rom (
    .sin_addr (addr),
    .cos_addr (addr + QUARTER),
    .sin_val  (rom_sin),
    .cos_val  (rom_cos)
  );

  always_comb phase_d = phase_q + tune;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      lo_cos  <= '0;
      lo_sin  <= '0;
    end else begin
      phase_q <= phase_d;
      lo_cos  <= rom_cos;
      lo_sin  <= rom_sin;
    end
  end

  // R3: phase advances by the word seen on the previous edge, wrapping
  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> phase_q == PH_W'($past(phase_q) + $past(tune)));
endmodule

// File: rtl/ddc_cic.sv
module ddc_cic #(
  parameter int IN_W  = 22,
  parameter int N     = ddc_pkg::CIC_N,
  parameter int R     = ddc_pkg::CIC_R,
  parameter int OUT_W = ddc_pkg::OUT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout,
  output logic                    dvalid
);
  localparam int W     = IN_W + N * $clog2(R);
  localparam int CNT_W = $clog2(R);

  logic signed [W-1:0] integ_q [N];
  logic signed [W-1:0] integ_d [N];
  logic signed [W-1:0] dly_q   [N];
  logic signed [W-1:0] dly_d   [N];
  logic signed [W-1:0] tap     [N+1];
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                dec;
  logic signed [OUT_W-1:0] dout_d;

  always_comb begin
    dec   = (cnt_q == CNT_W'(R - 1));
    cnt_d = dec ? '0 : cnt_q + 1'b1;
    integ_d[0] = integ_q[0] + W'(din);
    for (int s = 1; s < N; s++) integ_d[s] = integ_q[s] + integ_q[s-1];
    tap[0] = integ_q[N-1];
    for (int s = 0; s < N; s++) begin
      tap[s+1] = tap[s] - dly_q[s];
      dly_d[s] = dec ? tap[s] : dly_q[s];
    end
    dout_d = dec ? tap[N][W-1 -: OUT_W] : dout;
  end

  for (genvar s = 0; s < N; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        integ_q[s] <= '0;
        dly_q[s]   <= '0;
      end else begin
        integ_q[s] <= integ_d[s];
        dly_q[s]   <= dly_d[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dout   <= '0;
      dvalid <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dout   <= dout_d;
      dvalid <= dec;
    end
  end

  // Checker counter: clocks since reset or since the last strobe
  logic [CNT_W:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (dvalid) gap_q <= (CNT_W+1)'(1);
    else             gap_q <= gap_q + 1'b1;
  end

  // R6: strobes are exactly R clocks apart, the first R clocks after reset
  p_valid_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> gap_q == (CNT_W+1)'(R));
  p_valid_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= (CNT_W+1)'(R));
  // R8: output word holds between strobes
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dvalid |-> $stable(dout));
endmodule

// File: rtl/ddc_frontend.sv
module ddc_frontend #(
  parameter int ADC_W  = ddc_pkg::ADC_W,
  parameter int PH_W   = ddc_pkg::PH_W,
  parameter int LUT_AW = ddc_pkg::LUT_AW,
  parameter int LUT_DW = ddc_pkg::LUT_DW,
  parameter int CIC_N  = ddc_pkg::CIC_N,
  parameter int CIC_R  = ddc_pkg::CIC_R,
  parameter int OUT_W  = ddc_pkg::OUT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADC_W-1:0]        adc_code,
  input  logic [PH_W-1:0]         tune_word,
  output logic signed [OUT_W-1:0] i_out,
  output logic signed [OUT_W-1:0] q_out,
  output logic                    out_valid
);
  localparam int              PROD_W = ADC_W + LUT_DW;
  localparam logic [ADC_W-1:0] MID   = ADC_W'(2 ** (ADC_W - 1));

  logic [1:0]                rst_sync_q;
  logic                      rst_core_n;
  logic signed [ADC_W-1:0]   smp_q, smp_d;
  logic signed [LUT_DW-1:0]  lo_cos, lo_sin;
  logic signed [PROD_W-1:0]  prod_i_q, prod_q_q, prod_i_d, prod_q_d;
  logic                      valid_q_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ddc_nco #(.PH_W(PH_W), .AW(LUT_AW), .DW(LUT_DW)) u_nco (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tune   (tune_word),
    .lo_cos (lo_cos),
    .lo_sin (lo_sin)
  );

  always_comb begin
    smp_d    = signed'(adc_code - MID);
    prod_i_d = PROD_W'(smp_q) * PROD_W'(lo_cos);
    prod_q_d = PROD_W'(smp_q) * PROD_W'(lo_sin);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      smp_q    <= '0;
      prod_i_q <= '0;
      prod_q_q <= '0;
    end else begin
      smp_q    <= smp_d;
      prod_i_q <= prod_i_d;
      prod_q_q <= prod_q_d;
    end
  end

  ddc_cic #(.IN_W(PROD_W), .N(CIC_N), .R(CIC_R), .OUT_W(OUT_W)) u_cic_i (
    .clk (clk), .rst_n (rst_core_n), .din (prod_i_q), .dout (i_out), .dvalid (out_valid)
  );

  ddc_cic #(.IN_W(PROD_W), .N(CIC_N), .R(CIC_R), .OUT_W(OUT_W)) u_cic_q (
    .clk (clk), .rst_n (rst_core_n), .din (prod_q_q), .dout (q_out), .dvalid (valid_q_ch)
  );

  // R2: registered sample is the previous code minus mid-scale
  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    $past(rst_core_n) |-> smp_q == signed'(ADC_W'($past(adc_code) - MID)));
  // R9: both channels strobe together
  p_iq_aligned_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid == valid_q_ch);
  // R1: nothing valid while the core is held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_core_n |-> !out_valid && i_out == '0 && q_out == '0);
endmodule

// File: tb/ddc_frontend_tb.sv
module ddc_frontend_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  adc_code = 10'd512;
  logic [23:0] tune_word = '0;
  logic signed [15:0] i_out, q_out;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ddc_frontend u_dut (
    .clk (clk), .rst_n (rst_n), .adc_code (adc_code), .tune_word (tune_word),
    .i_out (i_out), .q_out (q_out), .out_valid (out_valid)
  );

  // Table value per R4, written from the stated formula
  function automatic int lut(input int k);
    longint h, u, m;
    h = longint'(k % 512);
    u = h * (512 - h);
    m = (longint'(2047) * 4 * u) / (longint'(327680) - u);
    return (k >= 512) ? -int'(m) : int'(m);
  endfunction

  function automatic logic signed [15:0] top_bits(input longint v);
    logic [63:0] t;
    t = v;
    return t[61:46];
  endfunction

  // Reference model of R1..R9, stepped once per rising edge
  bit [1:0]    m_rs;
  logic [23:0] m_ph;
  int          m_smp, m_c, m_s, m_pi, m_pq, m_cnt;
  longint      m_ii [5], m_iq [5], m_di [5], m_dq [5];
  logic signed [15:0] m_oi, m_oq;
  bit          m_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !m_rs[1]) begin
      m_ph = '0; m_smp = 0; m_c = 0; m_s = 0; m_pi = 0; m_pq = 0; m_cnt = 0;
      for (int s = 0; s < 5; s++) begin m_ii[s] = 0; m_iq[s] = 0; m_di[s] = 0; m_dq[s] = 0; end
      m_oi = '0; m_oq = '0; m_valid = 1'b0;
    end else begin
      longint ci, cq, ti, tq;
      bit dec;
      dec = (m_cnt == 199);
      if (dec) begin
        ci = m_ii[4]; cq = m_iq[4];
        for (int s = 0; s < 5; s++) begin
          ti = ci - m_di[s]; tq = cq - m_dq[s];
          m_di[s] = ci; m_dq[s] = cq;
          ci = ti; cq = tq;
        end
        m_oi = top_bits(ci); m_oq = top_bits(cq);
      end
      m_valid = dec;
      m_cnt = dec ? 0 : m_cnt + 1;
      for (int s = 4; s > 0; s--) begin
        m_ii[s] = m_ii[s] + m_ii[s-1];
        m_iq[s] = m_iq[s] + m_iq[s-1];
      end
      m_ii[0] = m_ii[0] + longint'(m_pi);
      m_iq[0] = m_iq[0] + longint'(m_pq);
      m_pi = m_smp * m_c;
      m_pq = m_smp * m_s;
      m_c = lut((int'(m_ph[23:14]) + 256) % 1024);
      m_s = lut(int'(m_ph[23:14]));
      m_smp = int'(adc_code) - 512;
      m_ph = m_ph + tune_word;
    end
    if (!rst_n) m_rs = 2'b00;
    else        m_rs = {m_rs[0], 1'b1};
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int gap = 0;
  int strobes = 0;
  bit randomize_adc = 1'b0;
  bit randomize_tune = 1'b0;

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      gap++;
      check("R6 strobe timing", out_valid, m_valid);
      if (out_valid) begin
        strobes++;
        check("R7 I value", i_out, m_oi);
        check("R8 Q value", q_out, m_oq);
        if (strobes > 1) check("R6 spacing", gap, 200);
        gap = 0;
      end
      if (randomize_adc)  adc_code = 10'($urandom);
      if (randomize_tune && ($urandom % 37 == 0)) tune_word = 24'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", out_valid, 0);
    check("R1 I in reset", i_out, 0);
    rst_n = 1'b1;
    // R1: quiet after release until the first strobe
    repeat (150) @(negedge clk);
    check("R1 valid before first strobe", out_valid, 0);
    check("R1 Q before first strobe", q_out, 0);
    gap = 150;
    // R2: mid-scale code gives zero, even with a moving oscillator
    adc_code = 10'd512; tune_word = 24'h123457;
    run(1400);
    check("R2 mid-scale I", i_out, 0);
    check("R2 mid-scale Q", q_out, 0);
    // R4/R5: full-scale DC at zero frequency, phase frozen at its current value
    begin
      int a, ci, si;
      longint gain, ei, eq;
      tune_word = '0;
      run(2);
      a = int'(m_ph[23:14]);
      adc_code = 10'd1023;
      run(2400);
      ci = lut((a + 256) % 1024); si = lut(a);
      gain = longint'(200) ** 5;
      ei = (longint'(511 * ci) * gain) >>> 46;
      eq = (longint'(511 * si) * gain) >>> 46;
      check("R4 settled I uses cosine", i_out, ei);
      check("R5 settled Q uses sine", q_out, eq);
      check("R9 I and Q together", out_valid, 0);
    end
    // R3: quarter-rate, wrap-around word, then random words and codes
    tune_word = 24'h400000; randomize_adc = 1'b1;
    run(2000);
    tune_word = 24'hFFFFFF;
    run(2000);
    randomize_tune = 1'b1;
    run(6000);
    adc_code = 10'd0; randomize_adc = 1'b0;
    run(2000);
    check("R3 strobes seen", (strobes > 60) ? 1 : 0, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule